// File: doc/BRIEF.md
# Load-Store Address Generator

This unit sits between instruction decode and the memory port of a small load-store processor. Each valid cycle it receives a 32-bit instruction word, the program counter, and the values read from two register-file ports. It works out the effective address for the memory-access and address-loading opcodes and issues the matching request one clock edge later. The outputs are a read request, a write request with store data, or a register write that carries the computed address itself.

Two address forms are produced. The first is a base-plus-offset form that adds a base register to a sign-extended 17-bit offset. A base field of zero selects no base at all, which gives absolute (direct) addressing. The second is a PC-relative form that adds a sign-extended 22-bit offset to the program counter. The PC supplied is the value already advanced by 4 at fetch. The unit drives the register indices for its two read ports straight from the instruction fields, so the register file answers in the same cycle.

Top module: `ls_addr_gen`

## Requirements
- R1: During and right after reset, `out_valid`, `mem_rd`, `mem_wr` and `reg_we` are 0.
- R2: Every instruction accepted with `in_valid` high produces exactly one result cycle with `out_valid` high on the next clock edge, in order. Without `in_valid`, `out_valid` is low on the next edge.
- R3: When the base field (bits 21..17) is 0, the base-plus-offset address equals the 17-bit offset (bits 16..0) sign-extended. The value of register 0 has no effect. Positive offsets land in 0x00000000-0x0000FFFF, and offsets with bit 16 set land in 0xFFFF0000-0xFFFFFFFF.
- R4: When the base field is nonzero, the address is the base register's value plus the sign-extended offset, modulo 2^32.
- R5: The PC-relative address is PC plus the sign-extended 22-bit offset (bits 21..0). Its reach is 2^21-1 bytes forward and 2^21 bytes backward.
- R6: Opcode 1 (bits 31..27) issues `mem_rd` at the base-plus-offset address, with `dest_idx` set to the target field (bits 26..22) and no register write.
- R7: Opcode 2 issues `mem_rd` at the PC-relative address, with `dest_idx` set to the target field.
- R8: Opcode 3 issues `mem_wr` at the base-plus-offset address. `mem_wdata` carries the register named by the target field, `dest_idx` is 0, and `reg_we` is 0.
- R9: Opcode 5 raises `reg_we` with `reg_wdata` equal to the base-plus-offset address and `dest_idx` equal to the target field. It makes no memory request.
- R10: Opcode 6 raises `reg_we` with `reg_wdata` equal to the PC-relative address. It makes no memory request.
- R11: Any other opcode gives a result cycle with no memory request and no register write. `mem_addr`, `reg_wdata`, `mem_wdata` and `dest_idx` are all 0 in that cycle.
- R12: At most one of `mem_rd`, `mem_wr`, `reg_we` is high in any cycle, and none is high without `out_valid`.
- R13: `base_sel` equals instruction bits 21..17 and `src_sel` equals bits 26..22, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction presented this cycle |
| instr | input | 32 | Instruction word |
| pc | input | 32 | Program counter, already advanced by 4 |
| base_sel | output | 5 | Register index for the base read port |
| base_val | input | 32 | Value of the register at `base_sel` |
| src_sel | output | 5 | Register index for the store-data read port |
| src_val | input | 32 | Value of the register at `src_sel` |
| out_valid | output | 1 | Result cycle for an accepted instruction |
| mem_addr | output | 32 | Effective memory address |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| mem_wdata | output | 32 | Store data |
| dest_idx | output | 5 | Destination register index |
| reg_we | output | 1 | Register write of the computed address |
| reg_wdata | output | 32 | Address value to write |

## Verification
On every cycle the embedded properties enforce the following: request exclusivity, no request without a result strobe, a result strobe only after an accepted instruction, and store data matching the store port's value from the previous cycle. The arithmetic cannot be shown that way. The sign extension at both offset widths, the direct-address ranges at the bit-16 boundary, modulo-2^32 wrap, and the forward and backward reach limits of the PC-relative form come only from the bench scenarios. The same holds for the proof that register 0's contents are ignored and that unused opcodes stay silent.

// File: rtl/lsag_pkg.sv
package lsag_pkg;
   localparam int OPC_W  = 5;
   localparam int RIDX_W = 5;

   localparam logic [OPC_W-1:0] OPC_LOAD      = 5'd1;
   localparam logic [OPC_W-1:0] OPC_LOAD_REL  = 5'd2;
   localparam logic [OPC_W-1:0] OPC_STORE     = 5'd3;
   localparam logic [OPC_W-1:0] OPC_ADDR      = 5'd5;
   localparam logic [OPC_W-1:0] OPC_ADDR_REL  = 5'd6;

   typedef enum logic [1:0] {
      ACT_NONE  = 2'd0,
      ACT_LOAD  = 2'd1,
      ACT_STORE = 2'd2,
      ACT_ADDR  = 2'd3
   } act_e;
endpackage

// File: rtl/lsag_field_decode.sv
module lsag_field_decode
   import lsag_pkg::*;
#(
   parameter int XLEN = 32,
   parameter int C1_W = 22,
   parameter int C2_W = 17
) (
   input  logic [XLEN-1:0]   instr,
   output logic [RIDX_W-1:0] ra,
   output logic [RIDX_W-1:0] rb,
   output logic [C1_W-1:0]   c1,
   output logic [C2_W-1:0]   c2,
   output act_e              act,
   output logic              use_rel
);
   localparam int OP_LSB = XLEN - OPC_W;
   localparam int RA_LSB = OP_LSB - RIDX_W;
   localparam int RB_LSB = RA_LSB - RIDX_W;

   if (C1_W > RA_LSB) begin : g_bad_c1
      $error("relative offset overlaps target field");
   end
   if (C2_W > RB_LSB) begin : g_bad_c2
      $error("short offset overlaps base field");
   end

   logic [OPC_W-1:0] opc;

   assign opc = instr[XLEN-1:OP_LSB];
   assign ra  = instr[OP_LSB-1:RA_LSB];
   assign rb  = instr[RA_LSB-1:RB_LSB];
   assign c1  = instr[C1_W-1:0];
   assign c2  = instr[C2_W-1:0];

   always_comb begin
      act     = ACT_NONE;
      use_rel = 1'b0;
      case (opc)
         OPC_LOAD:     act = ACT_LOAD;
         OPC_LOAD_REL: begin act = ACT_LOAD; use_rel = 1'b1; end
         OPC_STORE:    act = ACT_STORE;
         OPC_ADDR:     act = ACT_ADDR;
         OPC_ADDR_REL: begin act = ACT_ADDR; use_rel = 1'b1; end
         default:      act = ACT_NONE;
      endcase
   end
endmodule

// File: rtl/lsag_addr_calc.sv
module lsag_addr_calc
   import lsag_pkg::*;
#(
   parameter int XLEN           = 32,
   parameter int C1_W           = 22,
   parameter int C2_W           = 17,
   parameter bit ZERO_IS_DIRECT = 1'b1
) (
   input  logic [RIDX_W-1:0] rb,
   input  logic [XLEN-1:0]   base_val,
   input  logic [XLEN-1:0]   pc,
   input  logic [C1_W-1:0]   c1,
   input  logic [C2_W-1:0]   c2,
   output logic [XLEN-1:0]   disp_addr,
   output logic [XLEN-1:0]   rel_addr
);
   localparam int EXT1 = XLEN - C1_W;
   localparam int EXT2 = XLEN - C2_W;

   if (EXT1 < 1 || EXT2 < 1) begin : g_bad_w
      $error("offsets must be narrower than the datapath");
   end

   logic [XLEN-1:0] off_short;
   logic [XLEN-1:0] off_long;
   logic [XLEN-1:0] base_term;

   assign off_short = {{EXT2{c2[C2_W-1]}}, c2};
   assign off_long  = {{EXT1{c1[C1_W-1]}}, c1};

   if (ZERO_IS_DIRECT) begin : g_zero_direct
      assign base_term = (rb == '0) ? '0 : base_val;
   end else begin : g_zero_reg
      assign base_term = base_val;
   end

   assign disp_addr = base_term + off_short;
   assign rel_addr  = pc + off_long;
endmodule

// File: rtl/lsag_out_stage.sv
module lsag_out_stage
   import lsag_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  act_e              act,
   input  logic              use_rel,
   input  logic [RIDX_W-1:0] ra,
   input  logic [XLEN-1:0]   disp_addr,
   input  logic [XLEN-1:0]   rel_addr,
   input  logic [XLEN-1:0]   src_val,
   output logic              out_valid,
   output logic [XLEN-1:0]   mem_addr,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [XLEN-1:0]   mem_wdata,
   output logic [RIDX_W-1:0] dest_idx,
   output logic              reg_we,
   output logic [XLEN-1:0]   reg_wdata
);
   logic [XLEN-1:0] eff;
   logic            is_ld, is_st, is_ad;

   assign eff   = use_rel ? rel_addr : disp_addr;
   assign is_ld = in_valid && (act == ACT_LOAD);
   assign is_st = in_valid && (act == ACT_STORE);
   assign is_ad = in_valid && (act == ACT_ADDR);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         mem_addr  <= '0;
         mem_rd    <= 1'b0;
         mem_wr    <= 1'b0;
         mem_wdata <= '0;
         dest_idx  <= '0;
         reg_we    <= 1'b0;
         reg_wdata <= '0;
      end else begin
         out_valid <= in_valid;
         mem_rd    <= is_ld;
         mem_wr    <= is_st;
         reg_we    <= is_ad;
         mem_addr  <= (is_ld || is_st) ? eff : '0;
         reg_wdata <= is_ad ? eff : '0;
         mem_wdata <= is_st ? src_val : '0;
         dest_idx  <= (is_ld || is_ad) ? ra : '0;
      end
   end

   p_exclusive_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mem_rd, mem_wr, reg_we}));

   p_req_valid_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd || mem_wr || reg_we) |-> out_valid);

   p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid));

   p_store_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> (mem_wdata == $past(src_val) && dest_idx == '0));
endmodule

// File: rtl/ls_addr_gen.sv
module ls_addr_gen
   import lsag_pkg::*;
#(
   parameter int XLEN           = 32,
   parameter int C1_W           = 22,
   parameter int C2_W           = 17,
   parameter bit ZERO_IS_DIRECT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [XLEN-1:0]   instr,
   input  logic [XLEN-1:0]   pc,
   output logic [RIDX_W-1:0] base_sel,
   input  logic [XLEN-1:0]   base_val,
   output logic [RIDX_W-1:0] src_sel,
   input  logic [XLEN-1:0]   src_val,
   output logic              out_valid,
   output logic [XLEN-1:0]   mem_addr,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [XLEN-1:0]   mem_wdata,
   output logic [RIDX_W-1:0] dest_idx,
   output logic              reg_we,
   output logic [XLEN-1:0]   reg_wdata
);
   logic [RIDX_W-1:0] ra, rb;
   logic [C1_W-1:0]   c1;
   logic [C2_W-1:0]   c2;
   act_e              act;
   logic              use_rel;
   logic [XLEN-1:0]   disp_addr, rel_addr;

   lsag_field_decode #(.XLEN(XLEN), .C1_W(C1_W), .C2_W(C2_W)) u_dec (
      .instr(instr), .ra(ra), .rb(rb), .c1(c1), .c2(c2),
      .act(act), .use_rel(use_rel)
   );

   assign base_sel = rb;
   assign src_sel  = ra;

   lsag_addr_calc #(.XLEN(XLEN), .C1_W(C1_W), .C2_W(C2_W),
                    .ZERO_IS_DIRECT(ZERO_IS_DIRECT)) u_calc (
      .rb(rb), .base_val(base_val), .pc(pc), .c1(c1), .c2(c2),
      .disp_addr(disp_addr), .rel_addr(rel_addr)
   );

   lsag_out_stage #(.XLEN(XLEN)) u_out (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .act(act),
      .use_rel(use_rel), .ra(ra), .disp_addr(disp_addr),
      .rel_addr(rel_addr), .src_val(src_val), .out_valid(out_valid),
      .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .mem_wdata(mem_wdata), .dest_idx(dest_idx), .reg_we(reg_we),
      .reg_wdata(reg_wdata)
   );
endmodule

// File: tb/ls_addr_gen_test.sv
module ls_addr_gen_test;
   typedef struct packed {
      logic [31:0] addr;
      logic        rd;
      logic        wr;
      logic [31:0] wdata;
      logic [4:0]  dest;
      logic        we;
      logic [31:0] wval;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] instr = '0;
   logic [31:0] pc = '0;
   logic [4:0]  base_sel, src_sel, dest_idx;
   logic [31:0] base_val, src_val, mem_addr, mem_wdata, reg_wdata;
   logic        out_valid, mem_rd, mem_wr, reg_we;
   logic [31:0] regs [32];
   exp_t        q[$];
   string       tq[$];
   int          checks = 0;
   int          errors = 0;
   bit          done = 1'b0;

   always #10 clk = ~clk;

   assign base_val = regs[base_sel];
   assign src_val  = regs[src_sel];

   ls_addr_gen uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr), .pc(pc),
      .base_sel(base_sel), .base_val(base_val), .src_sel(src_sel),
      .src_val(src_val), .out_valid(out_valid), .mem_addr(mem_addr),
      .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
      .dest_idx(dest_idx), .reg_we(reg_we), .reg_wdata(reg_wdata)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] mk_d(int op, int ra, int rb, logic [16:0] c2);
      return {op[4:0], ra[4:0], rb[4:0], c2};
   endfunction

   function automatic logic [31:0] mk_r(int op, int ra, logic [21:0] c1);
      return {op[4:0], ra[4:0], c1};
   endfunction

   // driver: present one instruction and push the expected result
   task automatic issue(logic [31:0] iw, logic [31:0] p, string tag);
      exp_t e;
      logic [4:0]  op, ra, rb;
      logic [31:0] disp, rel, eff;
      @(negedge clk);
      instr = iw; pc = p; in_valid = 1'b1;
      op = iw[31:27]; ra = iw[26:22]; rb = iw[21:17];
      disp = ((rb == 0) ? 32'h0 : regs[rb]) + {{15{iw[16]}}, iw[16:0]};
      rel  = p + {{10{iw[21]}}, iw[21:0]};
      eff  = (op == 2 || op == 6) ? rel : disp;
      e = '0;
      case (op)
         1, 2: begin e.rd = 1; e.addr = eff; e.dest = ra; end
         3:    begin e.wr = 1; e.addr = eff; e.wdata = regs[ra]; end
         5, 6: begin e.we = 1; e.wval = eff; e.dest = ra; end
         default: ;
      endcase
      #1;
      chk({tag, " R13 base_sel"}, {27'd0, base_sel}, {27'd0, rb});
      chk({tag, " R13 src_sel"}, {27'd0, src_sel}, {27'd0, ra});
      q.push_back(e);
      tq.push_back(tag);
   endtask

   task automatic idle();
      @(negedge clk);
      in_valid = 1'b0;
      instr = 32'hFFFF_FFFF;
   endtask

   // monitor: compare results a quarter period after the edge
   initial begin
      forever begin
         @(posedge clk);
         #5;
         if (rst_n && out_valid) begin
            if (q.size() == 0) begin
               chk("R2 unexpected out_valid", 32'd1, 32'd0);
            end else begin
               exp_t e;
               string t;
               e = q.pop_front();
               t = tq.pop_front();
               chk({t, " mem_addr"}, mem_addr, e.addr);
               chk({t, " mem_rd"}, {31'd0, mem_rd}, {31'd0, e.rd});
               chk({t, " mem_wr"}, {31'd0, mem_wr}, {31'd0, e.wr});
               chk({t, " mem_wdata"}, mem_wdata, e.wdata);
               chk({t, " dest_idx"}, {27'd0, dest_idx}, {27'd0, e.dest});
               chk({t, " reg_we"}, {31'd0, reg_we}, {31'd0, e.we});
               chk({t, " reg_wdata"}, reg_wdata, e.wval);
            end
         end else if (rst_n) begin
            chk("R12 idle no request", {29'd0, mem_rd, mem_wr, reg_we}, 32'd0);
         end
      end
   end

   initial begin
      #2_000_000;
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 32; i++) regs[i] = 32'h1000_0000 * i + 32'h11 * i;
      regs[0] = 32'hDEAD_0000;
      regs[3] = 32'h0000_0004;
      regs[4] = 32'h0000_1000;
      regs[9] = 32'h0000_2000;
      regs[12] = 32'hFFFF_FFF0;
      repeat (3) @(posedge clk);
      #5;
      chk("R1 out_valid in reset", {31'd0, out_valid}, 32'd0);
      chk("R1 requests in reset", {29'd0, mem_rd, mem_wr, reg_we}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #5;
      chk("R1 out_valid after reset", {31'd0, out_valid}, 32'd0);

      issue(mk_d(1, 1, 0, 17'h0FFFF), 32'h100, "R3 R6 direct top positive");
      issue(mk_d(1, 2, 0, 17'h10000), 32'h100, "R3 direct bottom negative");
      issue(mk_d(1, 5, 0, 17'h00020), 32'h100, "R3 reg0 ignored");
      issue(mk_d(1, 22, 4, 17'd24), 32'h100, "R4 R6 base plus offset");
      issue(mk_d(1, 8, 3, -17'sd8), 32'h100, "R4 wrap below zero");
      issue(mk_d(1, 8, 12, 17'h00020), 32'h100, "R4 wrap above top");
      idle();
      issue(mk_d(3, 4, 9, 17'd0), 32'h200, "R8 store indirect");
      issue(mk_d(3, 30, 4, 17'h1FFFC), 32'h200, "R8 store neg offset");
      issue(mk_r(2, 12, -22'sd48), 32'h5000, "R5 R7 relative back");
      issue(mk_r(2, 13, 22'h1FFFFF), 32'h5000, "R5 max forward");
      issue(mk_r(2, 14, 22'h200000), 32'h0030_0000, "R5 max backward");
      idle();
      idle();
      issue(mk_d(5, 7, 0, 17'd32), 32'h300, "R9 address direct");
      issue(mk_d(5, 7, 4, 17'h1FFFF), 32'h300, "R9 address based");
      issue(mk_r(6, 3, 22'd0), 32'h0000_4444, "R10 relative zero");
      issue(mk_r(6, 31, 22'h3FFFFC), 32'h0000_0002, "R10 relative wrap");
      issue(mk_d(0, 6, 4, 17'd8), 32'h400, "R11 opcode 0");
      issue(mk_d(4, 6, 4, 17'd8), 32'h400, "R11 opcode 4");
      issue(mk_d(7, 6, 0, 17'd8), 32'h400, "R11 opcode 7");
      issue(mk_d(12, 6, 4, 17'd8), 32'h400, "R11 opcode 12");
      issue(mk_d(31, 6, 4, 17'd8), 32'h400, "R11 opcode 31");
      issue(mk_d(1, 9, 9, 17'd4), 32'h400, "R2 back to back after gap");
      idle();
      repeat (3) @(negedge clk);
      chk("R2 all results delivered", q.size(), 32'd0);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule